// File: doc/BRIEF.md
# Byte-Wide Memory Configuration Loader

This block reads configuration data out of an external byte-wide memory and turns it into a serial bit stream for a downstream configuration sequencer. It acts as bus master. It drives an incrementing byte address and waits a fixed number of system clocks for the memory to answer. It then captures the byte and shifts it out most-significant bit first, one bit for each cycle of a configuration clock that it generates itself.

A pulse on the start input begins a load from address zero. The configuration clock rate (fast or slow) and the address width (all 22 bits driven, or only the low 18 with the top four lines reading high) are captured at that pulse. They are held until the next start. The downstream sequencer ends the load by raising the stop input. The loader then parks with its clock low and its strobe quiet.

Top module: `cfg_par_loader`

## Requirements
- R1: After reset, `cclk_o` and `sdata_vld_o` are low, and `addr_o` reads 0x3C0000 (byte address zero, with the upper four lines high because narrow mode is the reset setting).
- R2: A `start_i` pulse seen while idle, with `stop_i` low, sets the byte address to zero and captures `fast_i` and `wide_i`. The first strobe comes RD_LAT + HALF system clocks after the clock edge that samples the start.
- R3: Exactly one byte is read from each address. The byte address steps by one after the eighth bit of a byte, and it is the only address in use while that byte is shifted.
- R4: Each byte goes out on `sdata_o` most-significant bit first, eight bits per byte. `sdata_vld_o` is a one-system-clock pulse in the same cycle that `cclk_o` rises, and marks the bit then on `sdata_o`.
- R5: Within a byte, `cclk_o` has a period of 2*HALF system clocks: low for HALF, then high for HALF. HALF is FAST_HALF when the captured fast select is 1, and SLOW_HALF otherwise. `cclk_o` stays low while idle and while waiting on memory.
- R6: A byte is captured from `mem_data_i` RD_LAT system clocks after its address is driven. Between the last strobe of one byte and the first strobe of the next there are 2*HALF + RD_LAT system clocks.
- R7: With the captured wide select at 1, all 22 address lines carry the byte address. With it at 0, `addr_o[21:18]` read 4'b1111 and `addr_o[17:0]` carry the low address bits.
- R8: In the cycle after `stop_i` is high, the loader is idle, with `cclk_o` low, no strobe, and `addr_o` held. A `start_i` that arrives while `stop_i` is high is ignored.
- R9: Changes on `fast_i` and `wide_i` while a load is running have no effect on the clock period or the address lines until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a load from address zero |
| stop_i | input | 1 | Halt fetching and park the configuration clock low |
| fast_i | input | 1 | Clock rate select, 1 = fast, captured at start |
| wide_i | input | 1 | Address width select, 1 = all 22 lines, captured at start |
| mem_data_i | input | 8 | Byte returned by the external memory |
| addr_o | output | 22 | Byte address to the external memory |
| cclk_o | output | 1 | Generated configuration clock |
| sdata_o | output | 1 | Serial configuration data |
| sdata_vld_o | output | 1 | One-cycle strobe on each rising configuration clock edge |

## Verification
Loads run at both clock rates and both address widths, with random memory contents keyed per run, and each strobed bit is compared with the expected byte for its address. The memory model returns the inverted byte until the address has been stable for the read latency, so a capture that is early by one cycle corrupts every bit. Strobe spacing is checked three ways: from start to the first bit, within a byte, and across a byte boundary. These three gaps separate errors in latency, in the half-period and in the byte count. Stops land at random points inside a byte, and a start is raised while stop is high, to show that the loader parks quietly with its address held. The rate select is flipped during each run to show that it has no effect.

// File: rtl/cfg_par_pkg.sv
package cfg_par_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } ld_state_e;
endpackage

// File: rtl/cfg_cclk_gen.sv
module cfg_cclk_gen #(
    parameter int FAST_HALF = 2,
    parameter int SLOW_HALF = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic fast_i,
    output logic cclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int MAX_HALF = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
    localparam int PH_W     = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;
    localparam logic [PH_W-1:0] FAST_LIM = PH_W'(FAST_HALF - 1);
    localparam logic [PH_W-1:0] SLOW_LIM = PH_W'(SLOW_HALF - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            cclk;
    } gen_t;

    gen_t            gen_d, gen_q;
    logic [PH_W-1:0] lim;
    logic            at_lim;

    always_comb begin
        gen_d  = gen_q;
        lim    = fast_i ? FAST_LIM : SLOW_LIM;
        at_lim = run_i && (gen_q.ph == lim);
        if (!run_i) begin
            gen_d = '0;
        end else if (at_lim) begin
            gen_d.ph   = '0;
            gen_d.cclk = ~gen_q.cclk;
        end else begin
            gen_d.ph = gen_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign cclk_o = gen_q.cclk;
    assign rise_o = at_lim && !gen_q.cclk;
    assign fall_o = at_lim && gen_q.cclk;

    // R5: phase counter never runs past the larger half-period limit
    a_r5_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(gen_q.ph) < MAX_HALF);
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              shift_i,
    output logic              msb_o,
    output logic              last_o
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.sr  = data_i;
            sh_d.cnt = '0;
        end else if (shift_i) begin
            sh_d.sr  = {sh_q.sr[DATA_W-2:0], 1'b0};
            sh_d.cnt = sh_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign msb_o  = sh_q.sr[DATA_W-1];
    assign last_o = (sh_q.cnt == LAST_IDX);

    // R4: a fresh byte is never loaded in the same cycle a bit is shifted
    a_r4_load_shift_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && shift_i));
    // R3: shifting past the last bit of a byte never happens
    a_r3_no_extra_shift: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> !shift_i);
endmodule

// File: rtl/cfg_par_loader.sv
module cfg_par_loader #(
    parameter int ADDR_W    = 22,
    parameter int LOW_W     = 18,
    parameter int DATA_W    = 8,
    parameter int RD_LAT    = 3,
    parameter int FAST_HALF = 2,
    parameter int SLOW_HALF = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              fast_i,
    input  logic              wide_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              cclk_o,
    output logic              sdata_o,
    output logic              sdata_vld_o
);
    import cfg_par_pkg::*;

    localparam int LAT_W = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
    localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(RD_LAT - 1);

    typedef struct packed {
        ld_state_e         state;
        logic [ADDR_W-1:0] addr;
        logic [LAT_W-1:0]  lat;
        logic              fast;
        logic              wide;
        logic              vld;
    } ld_t;

    ld_t  ld_d, ld_q;
    logic run, load, shift;
    logic edge_rise, edge_fall, last_bit;

    cfg_cclk_gen #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) u_cclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .fast_i (ld_q.fast),
        .cclk_o (cclk_o),
        .rise_o (edge_rise),
        .fall_o (edge_fall)
    );

    cfg_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .data_i  (mem_data_i),
        .shift_i (shift),
        .msb_o   (sdata_o),
        .last_o  (last_bit)
    );

    always_comb begin
        ld_d  = ld_q;
        run   = (ld_q.state == ST_SHIFT) && !stop_i;
        load  = 1'b0;
        shift = 1'b0;
        unique case (ld_q.state)
            ST_IDLE: begin
                if (start_i && !stop_i) begin
                    ld_d.state = ST_WAIT;
                    ld_d.addr  = '0;
                    ld_d.lat   = '0;
                    ld_d.fast  = fast_i;
                    ld_d.wide  = wide_i;
                end
            end
            ST_WAIT: begin
                if (ld_q.lat == LAT_LAST) begin
                    ld_d.state = ST_SHIFT;
                    load       = 1'b1;
                end else begin
                    ld_d.lat = ld_q.lat + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (edge_fall) begin
                    if (last_bit) begin
                        ld_d.state = ST_WAIT;
                        ld_d.addr  = ld_q.addr + 1'b1;
                        ld_d.lat   = '0;
                    end else begin
                        shift = 1'b1;
                    end
                end
            end
            default: ld_d.state = ST_IDLE;
        endcase
        if (stop_i) begin
            ld_d.state = ST_IDLE;
            load       = 1'b0;
            shift      = 1'b0;
        end
        ld_d.vld = edge_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_q <= '0;
        else        ld_q <= ld_d;
    end

    generate
        if (ADDR_W > LOW_W) begin : g_upper
            assign addr_o = {ld_q.wide ? ld_q.addr[ADDR_W-1:LOW_W] : {(ADDR_W-LOW_W){1'b1}},
                             ld_q.addr[LOW_W-1:0]};
        end else begin : g_flat
            assign addr_o = ld_q.addr;
        end
    endgenerate

    assign sdata_vld_o = ld_q.vld;

    // R4: strobe only in the cycle the configuration clock has just risen
    a_r4_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_vld_o |-> $rose(cclk_o));
    // R8: stop parks the clock low and silences the strobe
    a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!cclk_o && !sdata_vld_o && ld_q.state == ST_IDLE));
    // R3: the byte address only steps by one or restarts at zero
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ld_q.addr) |-> (ld_q.addr == $past(ld_q.addr) + 1'b1 || ld_q.addr == '0));
    // R5: clock stays low outside the shifting phase
    a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_q.state != ST_SHIFT) |-> !cclk_o);
    // R9: captured rate select is steady while a load runs
    a_r9_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_q.state != ST_IDLE && $past(ld_q.state) != ST_IDLE) |-> $stable(ld_q.fast));
endmodule

// File: tb/cfg_par_loader_bench.sv
module cfg_par_loader_bench;
    localparam int RD_LAT    = 3;
    localparam int FAST_HALF = 2;
    localparam int SLOW_HALF = 5;
    localparam int LIMIT     = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0, fast_i = 1'b0, wide_i = 1'b0;
    logic [7:0]  mem_data;
    logic [21:0] addr_o;
    logic        cclk_o, sdata_o, sdata_vld_o;

    cfg_par_loader #(.RD_LAT(RD_LAT), .FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) u_cfg_par_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .fast_i(fast_i), .wide_i(wide_i), .mem_data_i(mem_data),
        .addr_o(addr_o), .cclk_o(cclk_o), .sdata_o(sdata_o), .sdata_vld_o(sdata_vld_o)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    int cyc = 0;
    bit timeout = 0;
    int bit_total = 0, last_cyc = 0, start_cyc = 0, run_half = SLOW_HALF;
    bit run_wide = 0, quiet = 1;
    logic [31:0] key = 32'h1234_5678;
    int stab = 0;
    logic [21:0] prev_addr = '0;

    function automatic logic [7:0] memf(input logic [17:0] a, input logic [31:0] k);
        logic [31:0] m;
        m = {14'd0, a} * 32'd2654435761 ^ k;
        return m[7:0] ^ m[23:16];
    endfunction

    function automatic logic [21:0] exp_addr(input int n, input bit wide);
        logic [21:0] a;
        a = 22'(n);
        return wide ? a : (a | 22'h3C0000);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // memory model: inverted data until the address has been stable for RD_LAT clocks
    always @(negedge clk) begin
        if (addr_o == prev_addr) begin
            if (stab < 255) stab <= stab + 1;
        end else begin
            stab <= 0;
        end
        prev_addr <= addr_o;
    end
    always @* mem_data = (stab >= RD_LAT - 1) ? memf(addr_o[17:0], key) : ~memf(addr_o[17:0], key);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > LIMIT) timeout <= 1'b1;
    end

    // stream monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (quiet) begin
                chk(!sdata_vld_o && !cclk_o, "R8 quiet after stop", {cclk_o, sdata_vld_o}, 0);
            end else if (sdata_vld_o) begin
                automatic int pos = bit_total % 8;
                automatic int bn  = bit_total / 8;
                automatic logic [7:0] eb = memf(18'(bn), key);
                automatic int gap = cyc - last_cyc;
                automatic int eg;
                chk(cclk_o == 1'b1, "R4 strobe with cclk high", cclk_o, 1);
                chk(sdata_o == eb[7-pos], "R4 R3 serial bit msb first", sdata_o, eb[7-pos]);
                if (pos == 0)
                    chk(addr_o == exp_addr(bn, run_wide), "R3 R7 byte address", addr_o, exp_addr(bn, run_wide));
                if (bit_total == 0)      eg = cyc == 0 ? 0 : 0;
                if (bit_total == 0)      eg = 1 + RD_LAT + run_half;
                else if (pos == 0)       eg = 2*run_half + RD_LAT;
                else                     eg = 2*run_half;
                if (bit_total == 0) gap = cyc - start_cyc;
                chk(gap == eg, bit_total == 0 ? "R2 first strobe delay" :
                               (pos == 0 ? "R6 byte boundary gap" : "R5 R9 bit period"), gap, eg);
                last_cyc = cyc;
                bit_total = bit_total + 1;
            end
        end
    end

    task automatic do_run(input int nbytes, input bit fast, input bit wide, input int extra);
        logic [21:0] hold;
        @(negedge clk);
        key       = $urandom;
        run_half  = fast ? FAST_HALF : SLOW_HALF;
        run_wide  = wide;
        bit_total = 0;
        quiet     = 0;
        fast_i    = fast;
        wide_i    = wide;
        start_i   = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start_i = 1'b0;
        fast_i  = ~fast;   // R9: must not change the running rate
        wide_i  = ~wide;   // R9: must not change the address lines
        while (bit_total < nbytes*8 && !timeout) @(negedge clk);
        repeat (extra) @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        quiet = 1;
        hold  = addr_o;
        repeat (30) begin
            @(negedge clk);
            chk(addr_o == hold, "R8 address held after stop", addr_o, hold);
        end
        stop_i = 1'b0;
    endtask

    initial begin
        wait (timeout);
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [21:0] hold;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cclk_o == 1'b0, "R1 reset cclk", cclk_o, 0);
        chk(sdata_vld_o == 1'b0, "R1 reset strobe", sdata_vld_o, 0);
        chk(addr_o == 22'h3C0000, "R1 reset address", addr_o, 22'h3C0000);

        do_run(4, 1'b0, 1'b1, 7);    // slow, wide
        do_run(3, 1'b1, 1'b0, 3);    // fast, narrow

        // R8: start while stop is high is ignored
        hold = addr_o;
        @(negedge clk);
        stop_i  = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        stop_i = 1'b0;
        repeat (40) @(negedge clk);
        chk(addr_o == hold, "R8 start ignored under stop", addr_o, hold);

        for (int i = 0; i < 8; i++) begin
            do_run(2 + ($urandom % 6), bit'($urandom % 2), bit'($urandom % 2), $urandom % 20);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule